// File: doc/BRIEF.md
# Single-Wire Debug Bit Engine

This block is the host end of a one-wire, open-drain debug link, working at the level of single bits. The wire idles high through an external pull-up. The block only pulls it low or lets it go. A write bit is a fixed low pulse followed by a released interval. The length of that interval carries the value: a long gap means 0 and a short gap means 1.

To read, the host still makes the falling edge and then lets go of the wire. The target answers by holding the wire low for longer (0) or by letting it rise at once (1). The block samples the synchronized wire level at a programmable point after it lets go. It then waits until the wire is back high and a recovery time has passed before it reports the bit.

A framing layer above this block issues one request at a time through a valid/busy/done handshake. Every duration is a parameter counted in system clock cycles.

Top module: `sdl_bit_engine`

## Requirements
- R1: While reset is asserted and right after it, pad_drive_low, busy, done and rd_bit are all 0.
- R2: A request (req_valid high while busy is low) is accepted at that clock edge, and busy is high from the next cycle. The request code is req_op: 2'b00 sends a 0, 2'b01 sends a 1, and 2'b10 or 2'b11 reads one bit.
- R3: Each slot starts in the cycle after acceptance with pad_drive_low high for TX_LOW_CYC cycles (writes) or RD_LOW_CYC cycles (reads).
- R4: A written 0 then releases the wire for TX_GAP0_CYC cycles.
- R5: A written 1 then releases the wire for TX_GAP1_CYC cycles.
- R6: On a read, the synchronized wire level is captured RD_SAMPLE_CYC cycles after release, and rd_bit shows it. Low gives 0 and high gives 1. With two synchronizer stages, this is the pad level RD_SAMPLE_CYC-2 cycles after the last host-driven cycle.
- R7: After the sample, the engine waits until the synchronized wire reads high. It then waits RD_RECOV_CYC more cycles before it finishes.
- R8: A request presented while busy is high has no effect on the current slot, and no slot follows it.
- R9: pad_drive_low is only ever high while busy is high. The engine has no way to drive the wire high.
- R10: done is a one-cycle pulse in the first cycle with busy low after a slot. rd_bit holds its value while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bit request strobe |
| req_op | input | 2 | Request code: 00 write 0, 01 write 1, 1x read |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle pulse when a slot completes |
| rd_bit | output | 1 | Last bit sampled by a read slot |
| pad_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| pad_in | input | 1 | Raw wire level from the pad |

## Verification
A wrong internal state shows up at the pad or handshake pins within one cycle. A stray drive, a low pulse of the wrong length or a gap of the wrong length moves the edge of pad_drive_low or done by at least one cycle. The per-cycle reference in the bench catches that shift on the cycle it happens. A sampling point that is off by one cycle shows up as a flipped rd_bit in the boundary pair, where the target's hold ends exactly at the sampling point or one cycle earlier. A recovery wait that ignores the wire shows up as done arriving early on the long-hold read.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TX_LOW,
      ST_TX_GAP,
      ST_RD_LOW,
      ST_RD_WAIT,
      ST_RD_HIGH,
      ST_RD_RECOV
   } slot_state_t;

   localparam logic [1:0] OP_SEND0 = 2'b00;
   localparam logic [1:0] OP_SEND1 = 2'b01;

   // counter width able to hold the largest (duration - 1)
   function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b,
                                             input int unsigned c, input int unsigned d,
                                             input int unsigned e, input int unsigned f);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      if (f > m) m = f;
      if (m < 2) return 1;
      return $clog2(m);
   endfunction

endpackage

// File: rtl/sdl_line_sync.sv
module sdl_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdl_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdl_slot_timer.sv
module sdl_slot_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdl_slot_ctrl.sv
module sdl_slot_ctrl
   import sdl_pkg::*;
#(
   parameter int W             = 8,
   parameter int TX_LOW_CYC    = 50,
   parameter int TX_GAP0_CYC   = 200,
   parameter int TX_GAP1_CYC   = 50,
   parameter int RD_LOW_CYC    = 20,
   parameter int RD_SAMPLE_CYC = 30,
   parameter int RD_RECOV_CYC  = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic [1:0]   req_op,
   input  logic         line_s,
   input  logic         tmr_expired,
   output logic         tmr_load,
   output logic [W-1:0] tmr_val,
   output logic         busy,
   output logic         done,
   output logic         rd_bit,
   output logic         drive_low
);
   localparam logic [W-1:0] L_TX_LOW  = W'(TX_LOW_CYC - 1);
   localparam logic [W-1:0] L_GAP0    = W'(TX_GAP0_CYC - 1);
   localparam logic [W-1:0] L_GAP1    = W'(TX_GAP1_CYC - 1);
   localparam logic [W-1:0] L_RD_LOW  = W'(RD_LOW_CYC - 1);
   localparam logic [W-1:0] L_SAMPLE  = W'(RD_SAMPLE_CYC - 1);
   localparam logic [W-1:0] L_RECOV   = W'(RD_RECOV_CYC - 1);

   slot_state_t st_q, st_d;
   logic        bit_q;
   logic        drive_q;
   logic        done_q;
   logic        rd_q;
   logic        accept;
   logic        take_sample;

   assign accept      = (st_q == ST_IDLE) && req_valid;
   assign take_sample = (st_q == ST_RD_WAIT) && tmr_expired;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_op[1]) begin
                  st_d    = ST_RD_LOW;
                  tmr_val = L_RD_LOW;
               end else begin
                  st_d    = ST_TX_LOW;
                  tmr_val = L_TX_LOW;
               end
            end
         end
         ST_TX_LOW: begin
            if (tmr_expired) begin
               st_d     = ST_TX_GAP;
               tmr_load = 1'b1;
               tmr_val  = bit_q ? L_GAP1 : L_GAP0;
            end
         end
         ST_TX_GAP: begin
            if (tmr_expired) st_d = ST_IDLE;
         end
         ST_RD_LOW: begin
            if (tmr_expired) begin
               st_d     = ST_RD_WAIT;
               tmr_load = 1'b1;
               tmr_val  = L_SAMPLE;
            end
         end
         ST_RD_WAIT: begin
            if (tmr_expired) st_d = ST_RD_HIGH;
         end
         ST_RD_HIGH: begin
            if (line_s) begin
               st_d     = ST_RD_RECOV;
               tmr_load = 1'b1;
               tmr_val  = L_RECOV;
            end
         end
         ST_RD_RECOV: begin
            if (tmr_expired) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         bit_q   <= 1'b0;
         drive_q <= 1'b0;
         done_q  <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         st_q    <= st_d;
         drive_q <= (st_d == ST_TX_LOW) || (st_d == ST_RD_LOW);
         done_q  <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
         if (accept)      bit_q <= (req_op == OP_SEND1);
         if (take_sample) rd_q  <= line_s;
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign done      = done_q;
   assign rd_bit    = rd_q;
   assign drive_low = drive_q;
endmodule

// File: rtl/sdl_bit_engine.sv
module sdl_bit_engine
   import sdl_pkg::*;
#(
   parameter int TX_LOW_CYC    = 50,
   parameter int TX_GAP0_CYC   = 200,
   parameter int TX_GAP1_CYC   = 50,
   parameter int RD_LOW_CYC    = 20,
   parameter int RD_SAMPLE_CYC = 30,
   parameter int RD_RECOV_CYC  = 20,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   output logic       busy,
   output logic       done,
   output logic       rd_bit,
   output logic       pad_drive_low,
   input  logic       pad_in
);
   localparam int W = cnt_width(TX_LOW_CYC, TX_GAP0_CYC, TX_GAP1_CYC,
                                RD_LOW_CYC, RD_SAMPLE_CYC, RD_RECOV_CYC);

   generate
      if (TX_LOW_CYC < 1)    begin : g_chk_txlow  $error("TX_LOW_CYC must be >= 1");    end
      if (TX_GAP0_CYC < 1)   begin : g_chk_gap0   $error("TX_GAP0_CYC must be >= 1");   end
      if (TX_GAP1_CYC < 1)   begin : g_chk_gap1   $error("TX_GAP1_CYC must be >= 1");   end
      if (RD_LOW_CYC < 1)    begin : g_chk_rdlow  $error("RD_LOW_CYC must be >= 1");    end
      if (RD_SAMPLE_CYC < 1) begin : g_chk_sample $error("RD_SAMPLE_CYC must be >= 1"); end
      if (RD_RECOV_CYC < 1)  begin : g_chk_recov  $error("RD_RECOV_CYC must be >= 1");  end
   endgenerate

   logic         line_s;
   logic         tmr_load;
   logic [W-1:0] tmr_val;
   logic         tmr_expired;

   sdl_line_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (line_s)
   );

   sdl_slot_timer #(
      .W (W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdl_slot_ctrl #(
      .W             (W),
      .TX_LOW_CYC    (TX_LOW_CYC),
      .TX_GAP0_CYC   (TX_GAP0_CYC),
      .TX_GAP1_CYC   (TX_GAP1_CYC),
      .RD_LOW_CYC    (RD_LOW_CYC),
      .RD_SAMPLE_CYC (RD_SAMPLE_CYC),
      .RD_RECOV_CYC  (RD_RECOV_CYC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_op      (req_op),
      .line_s      (line_s),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .busy        (busy),
      .done        (done),
      .rd_bit      (rd_bit),
      .drive_low   (pad_drive_low)
   );
endmodule

// File: rtl/sdl_bit_engine_chk.sv
module sdl_bit_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic done,
   input logic rd_bit,
   input logic pad_drive_low
);
   // R9: the wire is pulled low only inside a slot
   a_r9_drive_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      pad_drive_low |-> busy);

   // R10: done lasts exactly one cycle
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: done coincides with the engine being idle
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: busy only falls together with a done pulse
   a_r10_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R2 / R3: an accepted request starts a slot with the wire pulled low
   a_r3_accept_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> (busy && pad_drive_low));

   // R10: the read result does not move while idle
   a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(rd_bit));
endmodule

bind sdl_bit_engine sdl_bit_engine_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .busy          (busy),
   .done          (done),
   .rd_bit        (rd_bit),
   .pad_drive_low (pad_drive_low)
);

// File: tb/sdl_bit_engine_test.sv
`timescale 1ns/1ps
module sdl_bit_engine_test;
   localparam int TL   = 4;
   localparam int G0   = 12;
   localparam int G1   = 4;
   localparam int TR   = 3;
   localparam int TS   = 5;
   localparam int TREC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic       busy, done, rd_bit, pad_drive_low;
   logic       tgt_low = 1'b0;
   logic       pad_in;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   assign pad_in = !(pad_drive_low || tgt_low);

   always #2.5 clk = ~clk;

   sdl_bit_engine #(
      .TX_LOW_CYC    (TL),
      .TX_GAP0_CYC   (G0),
      .TX_GAP1_CYC   (G1),
      .RD_LOW_CYC    (TR),
      .RD_SAMPLE_CYC (TS),
      .RD_RECOV_CYC  (TREC),
      .SYNC_STAGES   (2)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_op        (req_op),
      .busy          (busy),
      .done          (done),
      .rd_bit        (rd_bit),
      .pad_drive_low (pad_drive_low),
      .pad_in        (pad_in)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check3(input string tag, input int k,
                         input logic e_drv, input logic e_busy, input logic e_done);
      total++;
      if (pad_drive_low !== e_drv || busy !== e_busy || done !== e_done) begin
         bad++;
         $display("FAIL %s cycle %0d drv/busy/done actual=%b%b%b expected=%b%b%b",
                  tag, k, pad_drive_low, busy, done, e_drv, e_busy, e_done);
      end
   endtask

   task automatic check_rd(input string tag, input logic exp_v);
      total++;
      if (rd_bit !== exp_v) begin
         bad++;
         $display("FAIL %s rd_bit actual=%b expected=%b", tag, rd_bit, exp_v);
      end
   endtask

   task automatic idle_check(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check3(tag, i, 1'b0, 1'b0, 1'b0);
      end
   endtask

   // issues one request at the current negedge and follows the slot cycle by cycle
   task automatic run_slot(input logic [1:0] op, input int hold, input bit poke);
      int   lo, done_k, last_low, first_rel, m;
      bit   is_rd;
      logic exp_v;
      string tag;
      is_rd = op[1];
      exp_v = 1'b0;
      if (!is_rd) begin
         lo     = TL;
         done_k = TL + (op[0] ? G1 : G0) + 1;
      end else begin
         lo        = TR;
         last_low  = TR + hold;
         first_rel = TR + TS + 1;
         m         = (first_rel > last_low + 3) ? first_rel : last_low + 3;
         done_k    = m + TREC + 1;
         exp_v     = (last_low >= TR + TS - 2) ? 1'b0 : 1'b1;
      end
      req_valid = 1'b1;
      req_op    = op;
      for (int k = 1; k <= done_k; k++) begin
         @(negedge clk);
         req_valid = poke && (k == 2);
         req_op    = (poke && k == 2) ? 2'b10 : op;
         tgt_low   = is_rd && (hold > 0) && (k > TR) && (k <= TR + hold);
         if (k == 1)           tag = "R2";
         else if (k <= lo)     tag = "R3";
         else if (k == done_k) tag = "R10";
         else if (poke)        tag = "R8";
         else if (is_rd)       tag = "R7";
         else if (op[0])       tag = "R5";
         else                  tag = "R4";
         check3(tag, k, k <= lo, k < done_k, k == done_k);
      end
      tgt_low   = 1'b0;
      req_valid = 1'b0;
      if (is_rd) check_rd("R6", exp_v);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check3("R1", 0, 1'b0, 1'b0, 1'b0);
      check_rd("R1", 1'b0);
      rst_n = 1'b1;
      idle_check(2, "R1");

      run_slot(2'b00, 0, 1'b0);        // write 0
      run_slot(2'b01, 0, 1'b0);        // write 1, back to back
      run_slot(2'b10, 0, 1'b0);        // read, target answers 1
      run_slot(2'b11, TS + 4, 1'b0);   // read, long hold -> 0, late done
      idle_check(3, "R9");
      run_slot(2'b10, TS - 2, 1'b0);   // hold reaches the sample point -> 0
      run_slot(2'b10, TS - 3, 1'b0);   // hold ends one cycle early -> 1
      run_slot(2'b00, 0, 1'b1);        // request while busy ignored
      idle_check(4, "R8");
      run_slot(2'b10, 0, 1'b1);
      idle_check(3, "R8");
      check_rd("R10", 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule